// File: doc/BRIEF.md
# SPI Command Front End for a Double-Buffered 12-bit DAC

This block sits between a four-wire SPI bus and a 12-bit digital-to-analog converter core. While the active-low select is held low, a 16-bit shift register fills from the serial data input. Bits are taken on rising serial-clock edges, most significant bit first. The block interprets nothing until the select line returns high. At that edge the top four bits of the shift register are read as a command and the low twelve bits as a payload. The command decides how the payload moves between a holding register and the converter register. It can also put the converter to sleep or wake it.

The bus pins are oversampled by the block clock through a configurable synchronizer. Serial-clock and select transitions are found as edges in that clock domain. The most significant bit of the shift register is presented on a serial output that changes on falling serial-clock edges, so several devices can share one chained bus. A frame that is shorter or longer than 16 bits is still applied exactly as shifted. A sticky diagnostic flag records that the last frame had the wrong bit count.

Top module: `dac_spi_ctrl`

## Requirements
- R1: After reset the converter code, holding code, sleep flag, length flag and serial output are all 0.
- R2: Command code 0000 changes no register, whatever its payload.
- R3: Command code 0010 writes the 12-bit payload into the holding register and leaves the converter code and sleep flag unchanged.
- R4: Command code 0100 writes the payload into both the holding register and the converter register.
- R5: Command code 0110 copies the holding register into the converter register and leaves the holding register unchanged; its payload is ignored.
- R6: Command code 1000 sets the sleep flag and code 1100 clears it; neither changes the holding or converter registers.
- R7: The reserved codes (0001, 0011, 0101, 0111, 1001, 1010, 1011, 1101, 1110, 1111) change no register and leave the sleep flag unchanged.
- R8: Registers change only when select rises. The command is then bits 15..12 and the payload bits 11..0 of whatever the shift register holds, including after truncated or over-long frames.
- R9: When select rises after a bit count other than 16, the length flag is set and the frame is still applied. A frame of exactly 16 bits clears the flag.
- R10: The serial output takes bit 15 of the shift register on each falling serial-clock edge while selected, so in a 32-bit stream the first 16 bits reappear on it during the second 16.
- R11: Data is sampled on rising serial-clock edges only while select is low, and is shifted in most significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_sclk | input | 1 | Serial clock (idle low) |
| spi_csn | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data into the shift register |
| spi_sdo | output | 1 | Serial data out to the next device in a chain |
| dac_code | output | DATA_W | Code driving the converter core |
| hold_code | output | DATA_W | Contents of the holding register |
| sleep | output | 1 | Converter sleep state |
| frame_len_err | output | 1 | Last frame had a bit count other than 16 |

## Verification
The bench builds the block with a 12-bit payload, which gives a 16-bit frame, and a two-stage synchronizer. This fixes the pin-to-register latency at three clocks, and the behavioural model reproduces that latency with a short history of pin samples. With the short frame, 12-bit, 20-bit and 32-bit streams stay brief. That puts within reach the cases where leftover bits of the previous frame become the command field, where an over-long frame is applied from its last 16 bits, and where a whole preceding frame passes out on the serial output.

// File: rtl/dac_spi_pkg.sv
package dac_spi_pkg;

  localparam int unsigned CMD_W = 4;

  localparam logic [CMD_W-1:0] OP_NOP     = 4'b0000;
  localparam logic [CMD_W-1:0] OP_LD_HOLD = 4'b0010;
  localparam logic [CMD_W-1:0] OP_LD_BOTH = 4'b0100;
  localparam logic [CMD_W-1:0] OP_XFER    = 4'b0110;
  localparam logic [CMD_W-1:0] OP_SLEEP   = 4'b1000;
  localparam logic [CMD_W-1:0] OP_WAKE    = 4'b1100;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_HOLD,
    ACT_BOTH,
    ACT_XFER,
    ACT_SLEEP,
    ACT_WAKE
  } act_e;

  function automatic act_e decode_op(input logic [CMD_W-1:0] op);
    act_e a;
    case (op)
      OP_LD_HOLD: a = ACT_HOLD;
      OP_LD_BOTH: a = ACT_BOTH;
      OP_XFER:    a = ACT_XFER;
      OP_SLEEP:   a = ACT_SLEEP;
      OP_WAKE:    a = ACT_WAKE;
      default:    a = ACT_NONE;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/dac_spi_sync.sv
module dac_spi_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] stg_q [STAGES];
      logic [W-1:0] stg_d [STAGES];

      always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
          stg_d[i] = stg_q[i-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) begin
            stg_q[i] <= RST_VAL;
          end
        end else begin
          for (int i = 0; i < STAGES; i++) begin
            stg_q[i] <= stg_d[i];
          end
        end
      end

      assign q = stg_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/dac_spi_shifter.sv
module dac_spi_shifter #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               csn_s,
  input  logic               mosi_s,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   bit_cnt,
  output logic               cs_rise,
  output logic               sdo
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic               sclk_p, csn_p;
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               sdo_q, sdo_d;
  logic               sel, sclk_up, sclk_dn, cs_up, cs_dn;

  always_comb begin
    sel     = ~csn_s;
    sclk_up = sclk_s & ~sclk_p;
    sclk_dn = ~sclk_s & sclk_p;
    cs_up   = csn_s & ~csn_p;
    cs_dn   = ~csn_s & csn_p;
  end

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    sdo_d = sdo_q;
    if (cs_dn) begin
      cnt_d = '0;
    end
    if (sel && sclk_up) begin
      sr_d  = {sr_q[FRAME_W-2:0], mosi_s};
      cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    end
    if (sel && sclk_dn) begin
      sdo_d = sr_q[FRAME_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= 1'b0;
      csn_p  <= 1'b1;
      sr_q   <= '0;
      cnt_q  <= '0;
      sdo_q  <= 1'b0;
    end else begin
      sclk_p <= sclk_s;
      csn_p  <= csn_s;
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      sdo_q  <= sdo_d;
    end
  end

  assign frame   = sr_q;
  assign bit_cnt = cnt_q;
  assign cs_rise = cs_up;
  assign sdo     = sdo_q;

  // R10: serial output moves only after a falling serial clock while selected
  a_r10_sdo_on_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(~csn_s && sclk_p && ~sclk_s) |=> $stable(sdo_q));

  // R11: no shifting while deselected
  a_r11_no_shift_idle: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> $stable(sr_q));

  // R11: MSB-first shift takes the sampled data bit into position 0
  a_r11_lsb_gets_mosi: assert property (@(posedge clk) disable iff (!rst_n)
    (~csn_s && sclk_s && ~sclk_p) |=> (sr_q[0] == $past(mosi_s)));

endmodule

// File: rtl/dac_spi_cmdregs.sv
module dac_spi_cmdregs
  import dac_spi_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CNT_W  = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      latch,
  input  logic [CMD_W+DATA_W-1:0]   frame,
  input  logic [CNT_W-1:0]          bit_cnt,
  output logic [DATA_W-1:0]         hold_q,
  output logic [DATA_W-1:0]         dac_q,
  output logic                      sleep_q,
  output logic                      len_err_q
);

  localparam int unsigned FRAME_W = CMD_W + DATA_W;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [CMD_W-1:0]  op;
  logic [DATA_W-1:0] payload;
  act_e              act;
  logic [DATA_W-1:0] hold_d, dac_d;
  logic              sleep_d, len_err_d;

  always_comb begin
    op      = frame[FRAME_W-1 -: CMD_W];
    payload = frame[DATA_W-1:0];
    act     = decode_op(op);
  end

  always_comb begin
    hold_d    = hold_q;
    dac_d     = dac_q;
    sleep_d   = sleep_q;
    len_err_d = len_err_q;
    if (latch) begin
      len_err_d = (bit_cnt != CNT_FULL);
      case (act)
        ACT_HOLD:  hold_d = payload;
        ACT_BOTH:  begin
          hold_d = payload;
          dac_d  = payload;
        end
        ACT_XFER:  dac_d   = hold_q;
        ACT_SLEEP: sleep_d = 1'b1;
        ACT_WAKE:  sleep_d = 1'b0;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      dac_q     <= '0;
      sleep_q   <= 1'b0;
      len_err_q <= 1'b0;
    end else begin
      hold_q    <= hold_d;
      dac_q     <= dac_d;
      sleep_q   <= sleep_d;
      len_err_q <= len_err_d;
    end
  end

  // R8: nothing moves between select edges
  a_r8_quiet_without_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> ($stable(dac_q) && $stable(hold_q) && $stable(sleep_q)));

  // R3: holding-only load keeps the converter code
  a_r3_hold_only: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && op == 4'b0010) |=> ($stable(dac_q) && $stable(sleep_q)));

  // R5: transfer copies holding into converter and keeps holding
  a_r5_xfer_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && op == 4'b0110) |=> (dac_q == $past(hold_q) && $stable(hold_q)));

  // R7: reserved codes leave all state alone
  a_r7_reserved_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && !(op inside {4'b0000, 4'b0010, 4'b0100, 4'b0110, 4'b1000, 4'b1100}))
      |=> ($stable(dac_q) && $stable(hold_q) && $stable(sleep_q)));

  // R9: an exact-length frame clears the length flag
  a_r9_full_frame_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && bit_cnt == CNT_FULL) |=> !len_err_q);

endmodule

// File: rtl/dac_spi_ctrl.sv
module dac_spi_ctrl
  import dac_spi_pkg::*;
#(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_sdo,
  output logic [DATA_W-1:0] dac_code,
  output logic [DATA_W-1:0] hold_code,
  output logic              sleep,
  output logic              frame_len_err
);

  localparam int unsigned FRAME_W = CMD_W + DATA_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1) + 1;

  logic              rst_meta_q, rst_sync_q;
  logic [2:0]        pins_s;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]  bit_cnt;
  logic              cs_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  dac_spi_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .d    ({spi_sclk, spi_csn, spi_mosi}),
    .q    (pins_s)
  );

  dac_spi_shifter #(
    .FRAME_W(FRAME_W),
    .CNT_W  (CNT_W)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .sclk_s (pins_s[2]),
    .csn_s  (pins_s[1]),
    .mosi_s (pins_s[0]),
    .frame  (frame),
    .bit_cnt(bit_cnt),
    .cs_rise(cs_rise),
    .sdo    (spi_sdo)
  );

  dac_spi_cmdregs #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .latch    (cs_rise),
    .frame    (frame),
    .bit_cnt  (bit_cnt),
    .hold_q   (hold_code),
    .dac_q    (dac_code),
    .sleep_q  (sleep),
    .len_err_q(frame_len_err)
  );

  // R1: reset leaves every output at zero
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_q |=> (dac_code == '0 && hold_code == '0 && !sleep && !frame_len_err && !spi_sdo));

endmodule

// File: tb/dac_spi_ctrl_bench.sv
module dac_spi_ctrl_bench;

  localparam int DW   = 12;
  localparam int FW   = 16;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic sclk, csn, mosi;
  logic sdo, sleep, len_err;
  logic [DW-1:0] dac_code, hold_code;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit cmp_en = 0;
  logic [63:0] sdo_cap;

  always #5 clk = ~clk;

  dac_spi_ctrl #(.DATA_W(DW), .SYNC_STAGES(SYNC)) u_dac_spi_ctrl (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
    .spi_sdo(sdo), .dac_code(dac_code), .hold_code(hold_code),
    .sleep(sleep), .frame_len_err(len_err)
  );

  // Behavioural reference: pin history, then frame semantics
  logic h_sclk [SYNC+2];
  logic h_csn  [SYNC+2];
  logic h_mosi [SYNC+2];
  logic [FW-1:0] m_sr;
  int m_cnt;
  logic [DW-1:0] m_hold, m_dac;
  logic m_sleep, m_len, m_sdo;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC + 2; i++) begin
        h_sclk[i] = 1'b0; h_csn[i] = 1'b1; h_mosi[i] = 1'b0;
      end
      m_sr = '0; m_cnt = 0; m_hold = '0; m_dac = '0;
      m_sleep = 1'b0; m_len = 1'b0; m_sdo = 1'b0;
    end else begin
      for (int i = SYNC + 1; i > 0; i--) begin
        h_sclk[i] = h_sclk[i-1]; h_csn[i] = h_csn[i-1]; h_mosi[i] = h_mosi[i-1];
      end
      h_sclk[0] = sclk; h_csn[0] = csn; h_mosi[0] = mosi;
      if (h_csn[SYNC+1] && !h_csn[SYNC]) m_cnt = 0;
      if (!h_csn[SYNC] && !h_sclk[SYNC+1] && h_sclk[SYNC]) begin
        m_sr = {m_sr[FW-2:0], h_mosi[SYNC]};
        m_cnt++;
      end
      if (!h_csn[SYNC] && h_sclk[SYNC+1] && !h_sclk[SYNC]) m_sdo = m_sr[FW-1];
      if (!h_csn[SYNC+1] && h_csn[SYNC]) begin
        m_len = (m_cnt != FW);
        case (m_sr[FW-1:FW-4])
          4'h2: m_hold = m_sr[DW-1:0];
          4'h4: begin m_hold = m_sr[DW-1:0]; m_dac = m_sr[DW-1:0]; end
          4'h6: m_dac = m_hold;
          4'h8: m_sleep = 1'b1;
          4'hC: m_sleep = 1'b0;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R4 dac_code model", 32'(dac_code), 32'(m_dac));
      chk("R3 hold_code model", 32'(hold_code), 32'(m_hold));
      chk("R6 sleep model", 32'(sleep), 32'(m_sleep));
      chk("R9 len flag model", 32'(len_err), 32'(m_len));
      chk("R10 sdo model", 32'(sdo), 32'(m_sdo));
    end
  end

  task automatic frame_begin();
    csn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [63:0] val, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = val[i];
      repeat (4) @(negedge clk);
      sdo_cap = {sdo_cap[62:0], sdo};
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic frame_end();
    repeat (4) @(negedge clk);
    csn = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic send(input logic [63:0] val, input int n);
    frame_begin();
    shift_bits(val, n);
    frame_end();
  endtask

  task automatic expect_state(input string req, input logic [DW-1:0] h,
                              input logic [DW-1:0] d, input logic s, input logic e);
    chk({req, " hold"}, 32'(hold_code), 32'(h));
    chk({req, " dac"}, 32'(dac_code), 32'(d));
    chk({req, " sleep"}, 32'(sleep), 32'(s));
    chk({req, " lenflag"}, 32'(len_err), 32'(e));
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; csn = 1'b1; mosi = 1'b0; sdo_cap = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    cmp_en = 1;

    expect_state("R1", 12'h000, 12'h000, 1'b0, 1'b0);
    chk("R1 sdo", 32'(sdo), 32'h0);

    send(64'h2ABC, 16);
    expect_state("R3 load holding", 12'hABC, 12'h000, 1'b0, 1'b0);

    send(64'h6FFF, 16);
    expect_state("R5 transfer", 12'hABC, 12'hABC, 1'b0, 1'b0);

    send(64'h4123, 16);
    expect_state("R4 R11 load both", 12'h123, 12'h123, 1'b0, 1'b0);

    send(64'h0FFF, 16);
    expect_state("R2 nop", 12'h123, 12'h123, 1'b0, 1'b0);

    send(64'h2456, 16);
    expect_state("R3 holding only", 12'h456, 12'h123, 1'b0, 1'b0);
    send(64'h6000, 16);
    expect_state("R5 transfer again", 12'h456, 12'h456, 1'b0, 1'b0);

    send(64'h8777, 16);
    expect_state("R6 enter sleep", 12'h456, 12'h456, 1'b1, 1'b0);
    send(64'hC777, 16);
    expect_state("R6 leave sleep", 12'h456, 12'h456, 1'b0, 1'b0);

    for (int c = 0; c < 16; c++) begin
      if (!(c inside {0, 2, 4, 6, 8, 12})) begin
        send({48'h0, c[3:0], 12'h5A5}, 16);
        expect_state("R7 reserved", 12'h456, 12'h456, 1'b0, 1'b0);
      end
    end

    frame_begin();
    shift_bits(64'h4777, 16);
    repeat (10) @(negedge clk);
    expect_state("R8 no change while selected", 12'h456, 12'h456, 1'b0, 1'b0);
    frame_end();
    expect_state("R8 applied on select rise", 12'h777, 12'h777, 1'b0, 1'b0);

    send(64'h0004, 16);
    send(64'hABC, 12);
    expect_state("R8 R9 truncated frame", 12'hABC, 12'hABC, 1'b0, 1'b1);

    send(64'h0000, 16);
    expect_state("R9 full frame clears", 12'hABC, 12'hABC, 1'b0, 1'b0);

    send(64'hC2345, 20);
    expect_state("R9 R8 long frame", 12'h345, 12'hABC, 1'b0, 1'b1);

    send(64'h9A5C_2321, 32);
    expect_state("R10 chained stream", 12'h321, 12'hABC, 1'b0, 1'b1);
    chk("R10 passed-through word", 32'(sdo_cap[15:0]), 32'h9A5C);

    send(64'h6000, 16);
    expect_state("R5 R9 after chain", 12'h321, 12'h321, 1'b0, 1'b0);

    cmp_en = 0;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule